// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Page Buffer

This block is the bus-facing side of a serial EEPROM on a two-wire bus. It oversamples the clock and data lines with the system clock and recognises start and stop conditions. When a frame names its 7-bit device address, the block takes part in it. A write frame loads a two-byte word address and then up to a page of data bytes into a page buffer. The stop that ends the frame starts a timed programming cycle. When that cycle ends, every buffered byte is copied into the storage array in the same clock.

Reads shift bytes out of the array, most significant bit first, from an internal address pointer. The pointer steps after every byte sent, so a master can read any run of bytes in one frame, and a later frame can resume where the last one ended. The data line is open drain: the block only ever pulls it low, through `sda_oe`, and an external pull-up or wired-AND supplies the high level.

Top module: `eei_i2c_slave`

## Requirements
- R1: The slave changes `sda_oe` only while the synchronised clock line is low. An acknowledge keeps the data line low from the falling clock edge before the ninth clock until the falling edge after it, so the line is low for the whole high phase of that clock.
- R2: The first byte after a start holds the device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The slave acknowledges only when bits 7..1 equal `DEV_ADDR`. Otherwise it leaves the line released until the next start or stop.
- R3: In a write frame the slave acknowledges the high address byte, the low address byte and every data byte that follows.
- R4: Only the low `ADDR_W-8` bits (4 by default) of the high address byte are used. The upper bits are ignored, so the word address has 12 bits.
- R5: During a write, each data byte goes to the buffer slot given by the low `PAGE_W` (5) address bits. Those bits then step by one and wrap inside the same 32-byte page. A 33rd byte overwrites the slot of the first.
- R6: Programming starts only at a stop that follows at least one data byte, and it lasts `WRITE_CYCLES` system clocks. While it runs, the slave acknowledges nothing, not even its own address. A repeated start before the stop discards the buffered bytes and does not start a programming cycle.
- R7: In a read, the slave sends 8 bits MSB first and releases the line for the ninth clock. If the master acknowledges, it sends the next byte. The 12-bit pointer steps after each byte sent and rolls over from 0xFFF to 0x000.
- R8: When the master does not acknowledge a read byte, the slave keeps the line released until a stop or start. A read frame that gives no address starts at the address after the last byte sent.
- R9: After reset the data line is released and the slave waits for a start.
- R10: A start is the data line falling while the clock is high, and a stop is it rising while the clock is high. A repeated start at any bit position restarts byte framing with a new device address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench writes a page that starts two bytes before the end of a page. A design that carries the increment into the page bits would store the wrapped bytes in the next page. It also sends 33 bytes, which must overwrite the first slot and not spill anywhere. It addresses the slave right after a stop, while it is programming, and a design that ignores the busy state would acknowledge. It aborts a write with a repeated start, and programming must not begin: the old byte must remain and the next address must be acknowledged at once. It also checks that the pointer rolls over at 0xFFF, that the upper address bits are ignored, and that the slave stays released after a master not-acknowledge and after a repeated start in mid-byte.

// File: rtl/eei_pkg.sv
package eei_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK,
        ST_WAIT
    } bus_st_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } byte_kind_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic dev_match(input logic [7:0] b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

endpackage

// File: rtl/eei_line_sync.sv
module eei_line_sync
    import eei_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.scl   = scl_ff[1];
        ev.sda   = sda_ff[1];
        ev.rise  = !scl_d && scl_ff[1];
        ev.fall  = scl_d && !scl_ff[1];
        ev.start = scl_d && scl_ff[1] && sda_d && !sda_ff[1];
        ev.stop  = scl_d && scl_ff[1] && !sda_d && sda_ff[1];
    end

endmodule

// File: rtl/eei_page_store.sv
module eei_page_store #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [PAGE_W-1:0]        wr_idx,
    input  logic [7:0]               wr_data,
    input  logic                     drop,
    input  logic                     commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_page,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     pending
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask;
    logic [7:0]            mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (commit || drop) begin
            mask <= '0;
        end else if (wr_en) begin
            mask[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) pbuf[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (mask[i]) mem[{commit_page, PAGE_W'(i)}] <= pbuf[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign pending = |mask;

    // R6: the buffer is frozen while it is being copied
    a_r6_commit_no_fill: assert property (@(posedge clk) disable iff (rst)
        commit |-> !wr_en);

endmodule

// File: rtl/eei_i2c_slave.sv
module eei_i2c_slave
    import eei_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         ADDR_W       = 12,
    parameter int         PAGE_W       = 5,
    parameter int         WRITE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int TW = $clog2(WRITE_CYCLES + 1);

    bus_ev_t     ev;
    bus_st_t     st;
    byte_kind_t  kind;
    logic [3:0]  bitcnt;
    logic [7:0]  sh;
    logic [ADDR_W-1:0] ptr;
    logic        rd_q, mack_q, busy;
    logic [TW-1:0] timer;

    logic        byte_done, wr_en, commit, drop, pending;
    logic [7:0]  rd_data;

    eei_line_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign byte_done = (st == ST_RX) && ev.fall && (bitcnt == 4'd8);
    assign wr_en     = byte_done && (kind == K_DATA);
    assign commit    = busy && (timer == TW'(1));
    assign drop      = ev.start && !busy;

    eei_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_idx      (ptr[PAGE_W-1:0]),
        .wr_data     (sh),
        .drop        (drop),
        .commit      (commit),
        .commit_page (ptr[ADDR_W-1:PAGE_W]),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .pending     (pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            kind   <= K_DEV;
            bitcnt <= '0;
            sh     <= '0;
            ptr    <= '0;
            rd_q   <= 1'b0;
            mack_q <= 1'b0;
            busy   <= 1'b0;
            timer  <= '0;
        end else begin
            if (busy) begin
                timer <= timer - TW'(1);
                if (timer == TW'(1)) busy <= 1'b0;
            end
            if (ev.stop) begin
                st <= ST_IDLE;
                if (pending && !busy) begin
                    busy  <= 1'b1;
                    timer <= TW'(WRITE_CYCLES);
                end
            end else if (ev.start) begin
                bitcnt <= '0;
                kind   <= K_DEV;
                st     <= busy ? ST_WAIT : ST_RX;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.rise) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            st <= ST_RXACK;
                            case (kind)
                                K_DEV: begin
                                    if (dev_match(sh, DEV_ADDR)) begin
                                        rd_q <= sh[0];
                                        kind <= K_AHI;
                                    end else begin
                                        st <= ST_WAIT;
                                    end
                                end
                                K_AHI: begin
                                    ptr[ADDR_W-1:8] <= sh[ADDR_W-9:0];
                                    kind <= K_ALO;
                                end
                                K_ALO: begin
                                    ptr[7:0] <= sh;
                                    kind <= K_DATA;
                                end
                                default: ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                            endcase
                        end
                    end
                    ST_RXACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (rd_q) begin
                                sh  <= rd_data;
                                ptr <= ptr + ADDR_W'(1);
                                st  <= ST_TX;
                            end else begin
                                st <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == 4'd7) begin
                                st <= ST_TXACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (ev.rise) begin
                            mack_q <= !ev.sda;
                        end else if (ev.fall) begin
                            if (mack_q) begin
                                sh     <= rd_data;
                                ptr    <= ptr + ADDR_W'(1);
                                bitcnt <= '0;
                                st     <= ST_TX;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = (st == ST_RXACK) || ((st == ST_TX) && !sh[7]);

    // R1: data line only moves while the clock is low
    a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !ev.scl);

    // R6: nothing is driven during programming
    a_r6_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R6: an address attempt during programming is ignored
    a_r6_start_busy_waits: assert property (@(posedge clk) disable iff (rst)
        (ev.start && busy) |=> (st == ST_WAIT));

    // R5: page bits stay fixed across a data byte
    a_r5_page_fixed: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R7: pointer steps once per byte loaded for sending
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RXACK && ev.fall && rd_q && !ev.start && !ev.stop)
        |=> (ptr == $past(ptr) + ADDR_W'(1)));

    // R8: a missing master acknowledge ends the transfer with the line released
    a_r8_nack_release: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TXACK && ev.fall && !mack_q) |=> (st == ST_WAIT && !sda_oe));

endmodule

// File: tb/eei_i2c_slave_bench.sv
module eei_i2c_slave_bench;

    localparam logic [6:0] DEV = 7'h50;
    localparam int WC = 400;
    localparam int Q  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    wire  sda_bus = !(m_low || sda_oe);

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] wbuf [0:39];
    logic [7:0] rbuf [0:39];

    always #10 clk = !clk;

    eei_i2c_slave #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) u_eei_i2c_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_low = 1'b1; wt(2*Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_low = 1'b0; wt(2*Q);
    endtask

    task automatic put_bit(input bit b);
        m_low = !b; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_low = 1'b0; wt(Q);
        m_scl = 1'b1; wt(1);
        a1 = !sda_bus; wt(2*Q-2);
        a2 = !sda_bus; wt(1);
        m_scl = 1'b0; wt(Q);
        ack = a1 && a2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wt(Q); m_scl = 1'b1; wt(Q);
            b = {b[6:0], sda_bus};
            wt(Q); m_scl = 1'b0;
        end
        wt(Q);
        m_low = mack; wt(Q);
        m_scl = 1'b1; wt(2*Q);
        m_scl = 1'b0;
        m_low = 1'b0; wt(Q);
    endtask

    task automatic wr_frame(input logic [15:0] a, input int n, input bit do_stop, output bit acks);
        bit k;
        acks = 1'b1;
        bus_start();
        send_byte({DEV, 1'b0}, k); acks &= k;
        send_byte(a[15:8], k); acks &= k;
        send_byte(a[7:0], k); acks &= k;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], k); acks &= k;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_frame(input bit random, input logic [15:0] a, input int n, output bit acks);
        bit k;
        acks = 1'b1;
        if (random) begin
            bus_start();
            send_byte({DEV, 1'b0}, k); acks &= k;
            send_byte(a[15:8], k); acks &= k;
            send_byte(a[7:0], k); acks &= k;
        end
        bus_start();
        send_byte({DEV, 1'b1}, k); acks &= k;
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);
    endtask

    task automatic t_write_read();
        bit ak;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
        wr_frame(16'h0123, 2, 1'b1, ak);
        chk(ak, "R3 write frame acks (R1 R2)", ak, 1);
        wt(WC + 50);
        rd_frame(1'b1, 16'h0123, 2, ak);
        chk(ak, "R7 read frame acks", ak, 1);
        chk(rbuf[0] == 8'hA5, "R7 first byte", rbuf[0], 8'hA5);
        chk(rbuf[1] == 8'h5A, "R7 next byte", rbuf[1], 8'h5A);
    endtask

    task automatic t_current_read();
        bit ak;
        rd_frame(1'b1, 16'h0123, 1, ak);
        rd_frame(1'b0, 16'h0000, 1, ak);
        chk(rbuf[0] == 8'h5A, "R8 current address read", rbuf[0], 8'h5A);
    endtask

    task automatic t_wrong_dev();
        bit k;
        bus_start();
        send_byte({7'h52, 1'b0}, k);
        bus_stop();
        chk(!k, "R2 foreign address not acked", k, 0);
    endtask

    task automatic t_upper_bits();
        bit ak;
        wbuf[0] = 8'h3C;
        wr_frame(16'hF200, 1, 1'b1, ak);
        wt(WC + 50);
        rd_frame(1'b1, 16'h0200, 1, ak);
        chk(rbuf[0] == 8'h3C, "R4 upper address bits ignored", rbuf[0], 8'h3C);
    endtask

    task automatic t_busy();
        bit ak, k;
        wbuf[0] = 8'h66;
        wr_frame(16'h0300, 1, 1'b1, ak);
        bus_start();
        send_byte({DEV, 1'b0}, k);
        bus_stop();
        chk(!k, "R6 no ack while programming", k, 0);
        wt(WC + 50);
        bus_start();
        send_byte({DEV, 1'b0}, k);
        bus_stop();
        chk(k, "R6 ack after programming", k, 1);
        rd_frame(1'b1, 16'h0300, 1, ak);
        chk(rbuf[0] == 8'h66, "R6 programmed byte", rbuf[0], 8'h66);
    endtask

    task automatic t_discard();
        bit ak;
        wbuf[0] = 8'h77;
        wr_frame(16'h0300, 1, 1'b0, ak);
        rd_frame(1'b1, 16'h0300, 1, ak);
        chk(ak, "R6 repeated start does not start programming", ak, 1);
        chk(rbuf[0] == 8'h66, "R6 aborted data discarded", rbuf[0], 8'h66);
        wt(WC + 50);
        rd_frame(1'b1, 16'h0300, 1, ak);
        chk(rbuf[0] == 8'h66, "R6 still unchanged later", rbuf[0], 8'h66);
    endtask

    task automatic t_page_wrap();
        bit ak;
        wbuf[0] = 8'h10; wbuf[1] = 8'h11; wbuf[2] = 8'h12; wbuf[3] = 8'h13;
        wr_frame(16'h045E, 4, 1'b1, ak);
        wt(WC + 50);
        rd_frame(1'b1, 16'h045E, 2, ak);
        chk(rbuf[0] == 8'h10, "R5 page tail 0", rbuf[0], 8'h10);
        chk(rbuf[1] == 8'h11, "R5 page tail 1", rbuf[1], 8'h11);
        rd_frame(1'b1, 16'h0440, 2, ak);
        chk(rbuf[0] == 8'h12, "R5 wrapped to page start", rbuf[0], 8'h12);
        chk(rbuf[1] == 8'h13, "R5 wrapped second", rbuf[1], 8'h13);
    endtask

    task automatic t_overflow();
        bit ak;
        for (int i = 0; i < 33; i++) wbuf[i] = 8'h80 + 8'(i);
        wr_frame(16'h0500, 33, 1'b1, ak);
        chk(ak, "R5 all 33 bytes acked", ak, 1);
        wt(WC + 50);
        rd_frame(1'b1, 16'h0500, 2, ak);
        chk(rbuf[0] == 8'hA0, "R5 33rd byte overwrote slot 0", rbuf[0], 8'hA0);
        chk(rbuf[1] == 8'h81, "R5 slot 1 kept", rbuf[1], 8'h81);
    endtask

    task automatic t_rollover();
        bit ak;
        wbuf[0] = 8'hE1;
        wr_frame(16'h0FFF, 1, 1'b1, ak);
        wt(WC + 50);
        wbuf[0] = 8'hE2;
        wr_frame(16'h0000, 1, 1'b1, ak);
        wt(WC + 50);
        rd_frame(1'b1, 16'h0FFF, 2, ak);
        chk(rbuf[0] == 8'hE1, "R7 last address", rbuf[0], 8'hE1);
        chk(rbuf[1] == 8'hE2, "R7 rollover to zero", rbuf[1], 8'hE2);
    endtask

    task automatic t_nack_release();
        bit k;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, k);
        send_byte(8'h01, k);
        send_byte(8'h23, k);
        bus_start();
        send_byte({DEV, 1'b1}, k);
        recv_byte(1'b0, b);
        chk(b == 8'hA5, "R8 byte before nack", b, 8'hA5);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R8 line released after nack", b, 8'hFF);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, k);
        bus_stop();
        chk(k, "R8 standby after stop", k, 1);
    endtask

    task automatic t_mid_restart();
        bit k;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, k);
        put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b1}, k);
        chk(k, "R10 restart mid byte reframes", k, 1);
        recv_byte(1'b0, b);
        bus_stop();
        chk(b == 8'h5A, "R10 read after restart", b, 8'h5A);
    endtask

    initial begin
        wt(5);
        rst = 1'b0;
        wt(5);
        t_reset();
        t_write_read();
        t_current_read();
        t_wrong_dev();
        t_upper_bits();
        t_busy();
        t_discard();
        t_page_wrap();
        t_overflow();
        t_rollover();
        t_nack_release();
        t_mid_restart();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wt(190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule